// File: doc/BRIEF.md
# Single-Cycle 4-Bit Adder-Only Processor

This block is a tiny processor with 4-bit data. It finishes one instruction on every clock edge. Its program is a 16-word store of 8-bit instructions, presented on a flat input bus and read through combinational logic at the address held in a 4-bit program counter. The machine state is two working registers (A and B), a registered 4-bit output port, the program counter and one carry bit.

The datapath has one 4-bit adder and no function select. The adder always adds the instruction's low nibble (the immediate) to one operand, and a four-way selector picks that operand from A, B, the input port or constant zero. Moves, input reads and output writes are therefore all additions. Because the immediate is never masked, a non-zero immediate on a move changes its result. The only branches are an unconditional jump and a jump taken when carry is clear. Both work by loading the immediate into the program counter.

Top module: `cpu4_core`

## Requirements
- R1: An active-low asynchronous reset clears A, B, the output register, the carry bit and the program counter to zero, so execution restarts at word 0 with out_o equal to 0.
- R2: An instruction is 8 bits. Bits 7..4 are the opcode and bits 3..0 are the immediate. Opcodes 0000, 0001, 0010 and 0011 write A+imm, B+imm, in_i+imm and 0+imm to A, truncated to 4 bits.
- R3: Opcodes 0100, 0101, 0110 and 0111 write A+imm, B+imm, in_i+imm and 0+imm to B.
- R4: Opcode 1001 writes B+imm to the output register and opcode 1011 writes imm to it. The immediate is added even when a move or output is intended.
- R5: Every edge the carry bit takes the adder's carry-out. On jump opcodes the adder sums zero and imm, so carry is 0 after any jump instruction.
- R6: Opcode 1111 loads imm into the program counter.
- R7: Opcode 1110 loads imm into the program counter when carry is 0. When carry is 1 the program counter advances by one.
- R8: In every other case the program counter advances by one and wraps from 15 to 0.
- R9: Opcodes 1000, 1010, 1100 and 1101 change neither A, B nor the output register.
- R10: On any edge, at most one of A, B, the output register and a program-counter load is enabled. The registers that are not addressed keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_i | input | 4 | Input port operand |
| prog_i | input | 128 | Program store, word k at bits 8k+7..8k |
| out_o | output | 4 | Registered output port |

## Verification
The assertions check on every cycle that:
- at most one load enable is active;
- registers that are not addressed hold their value;
- the program counter either advances by one with wrap or takes the jump target, according to opcode and carry;
- carry is clear after any jump.

Only the bench's programs can show whole-program behaviour. These cover the counting loop that overflows B and falls through its conditional jump, the effect of a non-zero immediate on moves and outputs, program-counter wrap back to word 0, and unassigned opcodes leaving all visible state unchanged.

// File: rtl/cpu4_pkg.sv
package cpu4_pkg;
  localparam int OP_W = 4;

  // order matches opcode bits [1:0] of register-write instructions
  typedef enum logic [1:0] {
    SRC_A    = 2'b00,
    SRC_B    = 2'b01,
    SRC_IN   = 2'b10,
    SRC_ZERO = 2'b11
  } src_e;

  typedef struct packed {
    src_e src;
    logic ld_a;
    logic ld_b;
    logic ld_out;
    logic ld_pc;
  } ctrl_t;

  localparam logic [OP_W-1:0] OP_OUT_B   = 4'b1001;
  localparam logic [OP_W-1:0] OP_OUT_IMM = 4'b1011;
  localparam logic [OP_W-1:0] OP_JNC     = 4'b1110;
  localparam logic [OP_W-1:0] OP_JMP     = 4'b1111;
endpackage

// File: rtl/cpu4_fetch.sv
module cpu4_fetch #(
  parameter int ADDR_W  = 4,
  parameter int INSTR_W = 8,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic [DEPTH*INSTR_W-1:0] prog_i,
  input  logic [ADDR_W-1:0]        pc_i,
  output logic [INSTR_W-1:0]       instr_o
);
  logic [INSTR_W-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign words[i] = prog_i[i*INSTR_W +: INSTR_W];
  end

  assign instr_o = words[pc_i];
endmodule

// File: rtl/cpu4_decoder.sv
module cpu4_decoder
  import cpu4_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic            carry_i,
  output ctrl_t           ctrl_o
);
  always_comb begin
    ctrl_o = '{src: SRC_ZERO, ld_a: 1'b0, ld_b: 1'b0, ld_out: 1'b0, ld_pc: 1'b0};
    if (!op_i[3]) begin
      ctrl_o.src  = src_e'(op_i[1:0]);
      ctrl_o.ld_a = !op_i[2];
      ctrl_o.ld_b = op_i[2];
    end else begin
      unique case (op_i)
        OP_OUT_B: begin
          ctrl_o.src    = SRC_B;
          ctrl_o.ld_out = 1'b1;
        end
        OP_OUT_IMM: ctrl_o.ld_out = 1'b1;
        OP_JNC:     ctrl_o.ld_pc  = !carry_i;
        OP_JMP:     ctrl_o.ld_pc  = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/cpu4_pc.sv
module cpu4_pc #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o
);
  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= '0;
    else if (ld_i) pc_q <= target_i;
    else           pc_q <= pc_q + ADDR_W'(1);
  end

  assign pc_o = pc_q;

  // R8
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> pc_q == $past(pc_q) + ADDR_W'(1));
  // R6
  pc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> pc_q == $past(target_i));
endmodule

// File: rtl/cpu4_datapath.sv
module cpu4_datapath
  import cpu4_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] in_i,
  output logic [DATA_W-1:0] out_o,
  output logic              carry_o
);
  logic [DATA_W-1:0] a_q, b_q, out_q, operand, sum;
  logic              carry_q, cout;

  always_comb begin
    unique case (ctrl_i.src)
      SRC_A:   operand = a_q;
      SRC_B:   operand = b_q;
      SRC_IN:  operand = in_i;
      default: operand = '0;
    endcase
  end

  assign {cout, sum} = {1'b0, operand} + {1'b0, imm_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q     <= '0;
      b_q     <= '0;
      out_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      carry_q <= cout;
      if (ctrl_i.ld_a)   a_q   <= sum;
      if (ctrl_i.ld_b)   b_q   <= sum;
      if (ctrl_i.ld_out) out_q <= sum;
    end
  end

  assign out_o   = out_q;
  assign carry_o = carry_q;

  // R10
  a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.ld_a |=> $stable(a_q));
  // R10
  b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.ld_b |=> $stable(b_q));
  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.ld_out |=> $stable(out_q));
endmodule

// File: rtl/cpu4_core.sv
module cpu4_core
  import cpu4_pkg::*;
#(
  parameter int DATA_W   = 4,
  localparam int ADDR_W  = DATA_W,
  localparam int INSTR_W = OP_W + DATA_W,
  localparam int DEPTH   = 1 << ADDR_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DATA_W-1:0]        in_i,
  input  logic [DEPTH*INSTR_W-1:0] prog_i,
  output logic [DATA_W-1:0]        out_o
);
  logic [ADDR_W-1:0]  pc;
  logic [INSTR_W-1:0] instr;
  logic [OP_W-1:0]    op;
  logic [DATA_W-1:0]  imm;
  logic               carry;
  ctrl_t              ctrl;

  assign op  = instr[INSTR_W-1 -: OP_W];
  assign imm = instr[DATA_W-1:0];

  cpu4_fetch #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_fetch (
    .prog_i (prog_i),
    .pc_i   (pc),
    .instr_o(instr)
  );

  cpu4_decoder u_dec (
    .op_i   (op),
    .carry_i(carry),
    .ctrl_o (ctrl)
  );

  cpu4_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (ctrl.ld_pc),
    .target_i(imm),
    .pc_o    (pc)
  );

  cpu4_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_i (ctrl),
    .imm_i  (imm),
    .in_i   (in_i),
    .out_o  (out_o),
    .carry_o(carry)
  );

  // R10
  one_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl.ld_a, ctrl.ld_b, ctrl.ld_out, ctrl.ld_pc}));
  // R6
  jmp_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_JMP |=> pc == $past(imm));
  // R7
  jnc_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_JNC && carry) |=> pc == $past(pc) + ADDR_W'(1));
  // R7
  jnc_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_JNC && !carry) |=> pc == $past(imm));
  // R5
  jump_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op[3:1] == 3'b111 |=> !carry);
  // R4
  out_imm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_OUT_IMM |=> out_o == $past(imm));
endmodule

// File: tb/cpu4_core_test.sv
module cpu4_core_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [3:0]   in_i = 4'd0;
  logic [127:0] prog_i;
  logic [3:0]   out_o;
  logic [7:0]   rom [16];

  int  n_run = 0, n_fail = 0;
  bit  mon_en = 1'b0;

  typedef struct {
    logic [3:0] v;
    string      req;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < 16; i++) prog_i[i*8 +: 8] = rom[i];

  cpu4_core uut (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .in_i  (in_i),
    .prog_i(prog_i),
    .out_o (out_o)
  );

  task automatic check(logic [3:0] act, logic [3:0] exp, string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: out_o=%0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(logic [3:0] v, string req);
    exp_t e;
    e.v = v;
    e.req = req;
    q.push_back(e);
  endtask

  // monitor: one expected output per executed instruction
  always @(negedge clk) begin
    if (mon_en && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(out_o, e.v, e.req);
    end
  end

  task automatic clear_rom();
    for (int i = 0; i < 16; i++) rom[i] = 8'h00;
  endtask

  // R1: reset, then run until every queued item is compared
  task automatic run_queued();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(out_o, 4'd0, "R1 reset");
    rst_ni = 1'b1;
    @(posedge clk);
    mon_en = 1'b1;
    while (q.size() > 0) @(negedge clk);
    mon_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // counting loop: OUT B / ADD B,1 / JNC 0, then OUT Im A, JMP 4
    clear_rom();
    rom[0] = 8'b1001_0000;
    rom[1] = 8'b0101_0001;
    rom[2] = 8'b1110_0000;
    rom[3] = 8'b1011_1010;
    rom[4] = 8'b1111_0100;
    for (int i = 0; i < 16; i++) begin
      push(4'(i), "R4 out B");
      push(4'(i), "R3 add B");
      push(4'(i), "R7 jnc taken");
    end
    push(4'hA, "R5 carry falls through");
    push(4'hA, "R6 jmp hold");
    push(4'hA, "R6 jmp hold");
    run_queued();

    // mixed moves, immediate leak, taken/not taken JNC, pc wrap
    clear_rom();
    in_i = 4'd5;
    rom[0]  = 8'b0011_0011;  // A=3
    rom[1]  = 8'b0000_1110;  // A=1, carry
    rom[2]  = 8'b1110_0111;  // not taken
    rom[3]  = 8'b0100_0010;  // B=A+2=3
    rom[4]  = 8'b1001_0001;  // out=B+1=4
    rom[5]  = 8'b0010_0000;  // A=in=5
    rom[6]  = 8'b0110_0011;  // B=in+3=8
    rom[7]  = 8'b1000_1111;  // unassigned
    rom[8]  = 8'b1001_0000;  // out=8
    rom[9]  = 8'b0001_1001;  // A=B+9=1, carry
    rom[10] = 8'b0100_0000;  // B=A=1, no carry
    rom[11] = 8'b1110_1101;  // taken to 13
    rom[12] = 8'b1011_1111;  // skipped
    rom[13] = 8'b1001_0000;  // out=1
    rom[14] = 8'b0000_1111;  // A=0, carry
    rom[15] = 8'b1110_1100;  // not taken, wrap to 0
    for (int i = 0; i < 4; i++)  push(4'd0, "R2 moves A");
    for (int i = 0; i < 3; i++)  push(4'd4, "R4 imm leak");
    push(4'd4, "R9 op 1000");
    for (int i = 0; i < 4; i++)  push(4'd8, "R3 in B");
    for (int i = 0; i < 7; i++)  push(4'd1, "R7 jnc taken");
    push(4'd4, "R8 wrap");
    run_queued();

    // R9 unassigned opcodes, MOV B,Im, self jump
    clear_rom();
    rom[0] = 8'b0111_0110;
    rom[1] = 8'b1010_0011;
    rom[2] = 8'b1100_0001;
    rom[3] = 8'b1101_1111;
    rom[4] = 8'b1001_0000;
    rom[5] = 8'b1111_0101;
    for (int i = 0; i < 4; i++) push(4'd0, "R9 unassigned");
    push(4'd6, "R3 mov B imm");
    push(4'd6, "R6 self jump");
    push(4'd6, "R6 self jump");
    run_queued();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule